// File: doc/BRIEF.md
# Masked Pending-Interrupt Controller

This block gathers eight interrupt request lines into one level-sensitive interrupt toward a processor. Request sources raise and lower bits of an 8-bit pending register through a set vector and a clear vector, one bit per line. Software reaches the block through a byte-wide register port. Through it, software programs a blocking mask, reads the mask and the pending register back, and acknowledges one request by its number.

The mask is kept internally as an enable mask, the complement of the byte software writes. A written 1 therefore blocks its line, and a mask read returns the byte that was written. A second controller's mask register sits in the same port. It stores its byte unchanged for readback only and never affects the interrupt. That controller's pending register always reads as zero.

The interrupt output comes from a two-state machine. `IRQ_QUIET` means no enabled request is pending, and `IRQ_RAISED` means at least one is. The transition RAISE (`IRQ_QUIET` to `IRQ_RAISED`) fires when the next-cycle pending value ANDed with the next-cycle enable mask is nonzero. DROP (`IRQ_RAISED` to `IRQ_QUIET`) fires when that AND becomes zero. HOLD keeps the current state otherwise. Register-port address map: 0 primary mask (read/write), 1 primary pending (read only), 2 acknowledge (write only, reads 0), 3 secondary mask (read/write), 4 secondary pending (reads 0), 5 to 7 unmapped.

Top module: `masked_pic`

## Requirements
- R1: After reset the pending register is 0x00, the enable mask is 0x00 (a mask read returns 0xFF), the secondary mask is 0x00, `irq` is low and `rdata` is 0x00.
- R2: A write to address 0 stores the bitwise complement of `wdata` as the enable mask, so a 1 in the written byte blocks that line from the next clock edge on.
- R3: A read of address 0 returns the complement of the enable mask, which equals the byte last written there.
- R4: `irq` is registered. After every clock edge it equals the OR-reduction of (pending AND enable mask) as updated at that same edge, whatever caused the update (mask write, set, clear or acknowledge).
- R5: A write to address 2 clears the pending bit whose index is `wdata[3:0]`. The upper nibble is ignored, and index values 8 to 15 clear nothing.
- R6: Each 1 in `set_vec` sets the matching pending bit at the clock edge.
- R7: Each 1 in `clr_vec` clears the matching pending bit at the clock edge.
- R8: When set, clear and acknowledge meet in one cycle, they apply in the order set, then clear, then acknowledge.
- R9: A read of address 1 returns the pending register as held before the read's clock edge. `rdata` is registered, updates one edge after `rd_en` is sampled, and holds its value when no read is made.
- R10: A write to address 3 stores `wdata` unchanged as the secondary mask. A read of address 3 returns it, and it never changes `irq`.
- R11: A read of address 4 always returns 0x00.
- R12: Writes to addresses 1, 4, 5, 6 and 7 change no state. Reads of addresses 2, 5, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| set_vec | input | 8 | Per-line request set vector |
| clr_vec | input | 8 | Per-line request clear vector |
| irq | output | 1 | Level interrupt toward the processor |

## Verification
The enable mask, the pending register and the interrupt state all show at the ports within one clock edge. A wrongly stored or uninverted mask shows on the next mask read and on `irq` right after the write. A lost set, a missed clear or an acknowledge of the wrong bit shows on the next pending read. It shows on `irq` as soon as that line is enabled. A state machine that misses a RAISE or a DROP is seen on the very edge where the enabled-pending AND changes, because the bench compares `irq` with its own model after every edge.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    // Register-port address map
    localparam int ADR_PRI_MASK = 0;
    localparam int ADR_PRI_PEND = 1;
    localparam int ADR_PRI_ACK  = 2;
    localparam int ADR_SEC_MASK = 3;
    localparam int ADR_SEC_PEND = 4;

    // Interrupt output state machine
    typedef enum logic [1:0] {
        IRQ_QUIET  = 2'd0,
        IRQ_RAISED = 2'd1
    } irq_state_e;

    // Source selected for a register read
    typedef enum logic [1:0] {
        RD_ZERO     = 2'd0,
        RD_PRI_MASK = 2'd1,
        RD_PRI_PEND = 2'd2,
        RD_SEC_MASK = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic    wr_mask;
        logic    wr_ack;
        logic    wr_sec;
        rd_src_e rd_src;
    } port_ctl_t;

endpackage

// File: rtl/mpic_decode.sv
module mpic_decode
    import mpic_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output port_ctl_t         ctl
);

    logic hit_pri_mask;
    logic hit_pri_pend;
    logic hit_ack;
    logic hit_sec_mask;

    assign hit_pri_mask = (addr == ADDR_W'(ADR_PRI_MASK));
    assign hit_pri_pend = (addr == ADDR_W'(ADR_PRI_PEND));
    assign hit_ack      = (addr == ADDR_W'(ADR_PRI_ACK));
    assign hit_sec_mask = (addr == ADDR_W'(ADR_SEC_MASK));

    always_comb begin
        ctl.wr_mask = wr_en && hit_pri_mask;
        ctl.wr_ack  = wr_en && hit_ack;
        ctl.wr_sec  = wr_en && hit_sec_mask;
        // secondary pending, acknowledge and unmapped addresses read zero
        if (hit_pri_mask) begin
            ctl.rd_src = RD_PRI_MASK;
        end else if (hit_pri_pend) begin
            ctl.rd_src = RD_PRI_PEND;
        end else if (hit_sec_mask) begin
            ctl.rd_src = RD_SEC_MASK;
        end else begin
            ctl.rd_src = RD_ZERO;
        end
    end

endmodule

// File: rtl/mpic_pending.sv
module mpic_pending #(
    parameter int NUM_LINES = 8,
    parameter int ACK_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_vec,
    input  logic                 ack_wr,
    input  logic [ACK_IDX_W-1:0] ack_idx,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] pend_next
);

    // Per line: set first, then clear, then acknowledge
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic after_set;
        logic after_clr;
        logic ack_hit;

        assign after_set    = pend_q[i] | set_vec[i];
        assign after_clr    = after_set & ~clr_vec[i];
        assign ack_hit      = ack_wr && (ack_idx == ACK_IDX_W'(i));
        assign pend_next[i] = after_clr & ~ack_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_next;
        end
    end

endmodule

// File: rtl/mpic_mask_bank.sv
module mpic_mask_bank #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_mask,
    input  logic                 wr_sec,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] en_next,
    output logic [NUM_LINES-1:0] sec_q
);

    // Enable mask is kept as the complement of the written blocking byte
    assign en_next = wr_mask ? ~wdata : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_next;
        end
    end

    // Secondary mask: stored as written, readback only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (wr_sec) begin
            sec_q <= wdata;
        end
    end

endmodule

// File: rtl/mpic_irq_fsm.sv
module mpic_irq_fsm
    import mpic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_next,
    input  logic [NUM_LINES-1:0] en_next,
    output logic                 irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       any_live;

    assign any_live = |(pend_next & en_next);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RAISE, DROP, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (any_live) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (!any_live) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: begin
                state_d = IRQ_QUIET;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/masked_pic.sv
module masked_pic
    import mpic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 3,
    parameter int ACK_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] rdata,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_vec,
    output logic                 irq
);

    port_ctl_t            ctl;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] pend_next;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] en_next;
    logic [NUM_LINES-1:0] sec_q;
    logic [NUM_LINES-1:0] rd_value;

    mpic_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .ctl   (ctl)
    );

    mpic_pending #(
        .NUM_LINES (NUM_LINES),
        .ACK_IDX_W (ACK_IDX_W)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .ack_wr    (ctl.wr_ack),
        .ack_idx   (wdata[ACK_IDX_W-1:0]),
        .pend_q    (pend_q),
        .pend_next (pend_next)
    );

    mpic_mask_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (ctl.wr_mask),
        .wr_sec  (ctl.wr_sec),
        .wdata   (wdata),
        .en_q    (en_q),
        .en_next (en_next),
        .sec_q   (sec_q)
    );

    mpic_irq_fsm #(
        .NUM_LINES (NUM_LINES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_next (pend_next),
        .en_next   (en_next),
        .irq       (irq)
    );

    // Read mux: values held before the read edge
    always_comb begin
        unique case (ctl.rd_src)
            RD_PRI_MASK: rd_value = ~en_q;
            RD_PRI_PEND: rd_value = pend_q;
            RD_SEC_MASK: rd_value = sec_q;
            default:     rd_value = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_value;
        end
    end

endmodule

// File: rtl/mpic_checker.sv
module mpic_checker
    import mpic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 3,
    parameter int ACK_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_LINES-1:0] wdata,
    input logic [NUM_LINES-1:0] rdata,
    input logic [NUM_LINES-1:0] set_vec,
    input logic [NUM_LINES-1:0] clr_vec,
    input logic                 irq,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] en_q
);

    localparam int LINE_W = $clog2(NUM_LINES);

    logic mask_wr_c;
    logic ack_wr_c;
    logic ack_in_range;

    assign mask_wr_c    = wr_en && (addr == ADDR_W'(ADR_PRI_MASK));
    assign ack_wr_c     = wr_en && (addr == ADDR_W'(ADR_PRI_ACK));
    assign ack_in_range = (wdata[ACK_IDX_W-1:0] < ACK_IDX_W'(NUM_LINES));

    // R2
    a_r2_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_c |=> (en_q == ~$past(wdata)));

    // R3
    a_r3_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_PRI_MASK)) |=> (rdata == ~$past(en_q)));

    // R4
    a_r4_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(pend_q & en_q)));

    // R5
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_c && ack_in_range && set_vec == '0)
            |=> !pend_q[$past(wdata[LINE_W-1:0])]);

    // R6
    a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && !ack_wr_c)
            |=> ((pend_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

    // R7
    a_r7_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pend_q & $past(clr_vec)) == '0));

    // R11
    a_r11_sec_pend_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_SEC_PEND)) |=> (rdata == '0));

endmodule

bind masked_pic mpic_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .ACK_IDX_W (ACK_IDX_W)
) u_mpic_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .irq     (irq),
    .pend_q  (pend_q),
    .en_q    (en_q)
);

// File: tb/masked_pic_bench.sv
`timescale 1ns/1ps
module masked_pic_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       rd_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [7:0] set_vec;
    logic [7:0] clr_vec;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model
    logic [7:0] m_en;
    logic [7:0] m_pend;
    logic [7:0] m_sec;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    masked_pic u_masked_pic (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return ~m_en;
            3'd1:    return m_pend;
            3'd3:    return m_sec;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_pend(input logic [7:0] p, input logic [7:0] s,
                                              input logic [7:0] c, input logic ack,
                                              input logic [7:0] d);
        logic [7:0] n;
        n = (p | s) & ~c;
        if (ack && d[3:0] < 4'd8) n[d[2:0]] = 1'b0;
        return n;
    endfunction

    // One bus cycle; inputs driven at the falling edge, results sampled at the next one
    task automatic cycle(input logic w, input logic r, input logic [2:0] a,
                         input logic [7:0] d, input logic [7:0] s, input logic [7:0] c,
                         input string req);
        wr_en = w; rd_en = r; addr = a; wdata = d; set_vec = s; clr_vec = c;
        if (r) m_rdata = model_read(a);
        m_pend = model_pend(m_pend, s, c, w && a == 3'd2, d);
        if (w && a == 3'd0) m_en  = ~d;
        if (w && a == 3'd3) m_sec = d;
        @(posedge clk);
        @(negedge clk);
        check({req, " irq"}, {7'b0, irq}, {7'b0, |(m_pend & m_en)});
        if (r) check({req, " rdata"}, rdata, m_rdata);
        wr_en = 1'b0; rd_en = 1'b0; set_vec = '0; clr_vec = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        cycle(1'b1, 1'b0, a, d, 8'h00, 8'h00, req);
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        cycle(1'b0, 1'b1, a, 8'h00, 8'h00, 8'h00, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0;
        wdata = '0; set_vec = '0; clr_vec = '0;
        m_en = '0; m_pend = '0; m_sec = '0; m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        rd(3'd0, "R1 mask");
        check("R1 mask reads FF", rdata, 8'hFF);
        rd(3'd1, "R1 pend");
        rd(3'd3, "R1 sec");

        // R2 / R3: inverted storage, plain readback
        wr(3'd0, 8'hA5, "R2");
        rd(3'd0, "R3");
        check("R3 mask value", rdata, 8'hA5);
        cycle(1'b0, 1'b0, 3'd0, 8'h00, 8'hFF, 8'h00, "R6");
        check("R4 raised", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'hFF, "R2 block all");
        check("R4 dropped", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'hFE, "R2 enable line0");
        check("R4 raised again", {7'b0, irq}, 8'h01);

        // R5: acknowledge by index
        wr(3'd2, 8'h00, "R5 ack 0");
        check("R5 drop after ack", {7'b0, irq}, 8'h00);
        wr(3'd2, 8'h0F, "R5 index 15");
        rd(3'd1, "R5 pend after idx15");
        check("R5 idx15 no effect", rdata, 8'hFE);
        wr(3'd2, 8'hF3, "R5 upper nibble ignored");
        rd(3'd1, "R5 pend");
        check("R5 bit3 cleared", rdata, 8'hF6);

        // R7: clear vector
        cycle(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'hF0, "R7");
        rd(3'd1, "R7 pend");
        check("R7 pend value", rdata, 8'h06);

        // R8: same-cycle ordering
        cycle(1'b1, 1'b0, 3'd2, 8'h01, 8'h01, 8'h01, "R8 set-clr-ack");
        rd(3'd1, "R8 pend");
        check("R8 pend value", rdata, 8'h04);
        cycle(1'b1, 1'b0, 3'd2, 8'h03, 8'h18, 8'h00, "R8 ack beats set");
        rd(3'd1, "R8 pend2");
        check("R8 pend2 value", rdata, 8'h14);

        // R9: read returns pre-edge value while a set lands
        cycle(1'b0, 1'b1, 3'd1, 8'h00, 8'h80, 8'h00, "R9 pre-edge");
        check("R9 old value", rdata, 8'h14);
        cycle(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, "R9 hold");
        check("R9 rdata held", rdata, 8'h14);

        // R10 / R11: secondary controller
        wr(3'd0, 8'h00, "R10 enable all");
        wr(3'd3, 8'h3C, "R10 sec write");
        check("R10 irq unaffected", {7'b0, irq}, 8'h01);
        rd(3'd3, "R10 sec read");
        check("R10 sec value", rdata, 8'h3C);
        rd(3'd4, "R11");
        check("R11 zero", rdata, 8'h00);

        // R12: read-only and unmapped addresses
        wr(3'd1, 8'hFF, "R12 wr pend");
        wr(3'd4, 8'hFF, "R12 wr secpend");
        wr(3'd6, 8'h55, "R12 wr unmapped");
        rd(3'd1, "R12 pend unchanged");
        rd(3'd0, "R12 mask unchanged");
        rd(3'd3, "R12 sec unchanged");
        rd(3'd5, "R12 rd unmapped");
        check("R12 unmapped zero", rdata, 8'h00);
        rd(3'd2, "R12 rd ack");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [7:0] s;
            logic [7:0] c;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            s  = ($urandom_range(0, 2) == 0) ? 8'($urandom()) : 8'h00;
            c  = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h00;
            d  = 8'($urandom());
            case (op)
                0, 1:    cycle(1'b1, 1'b0, 3'd0, d, s, c, "R4 rnd mask");
                2, 3:    cycle(1'b1, 1'b0, 3'd2, d, s, c, "R8 rnd ack");
                4:       cycle(1'b1, 1'b0, 3'd3, d, s, c, "R10 rnd sec");
                5:       cycle(1'b1, 1'b0, 3'($urandom_range(4, 7)), d, s, c, "R12 rnd");
                6, 7, 8: cycle(1'b0, 1'b1, 3'($urandom_range(0, 7)), d, s, c, "R9 rnd read");
                default: cycle(1'b0, 1'b0, 3'd0, d, s, c, "R6 rnd idle");
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule